// File: doc/BRIEF.md
# Cascadable synchronous presettable counter

A 4-bit edge-triggered counter stage whose sequence length and clear behaviour are fixed when the block is elaborated. Set for a modulus of 10 it steps through 0..9, and set for 16 it steps through 0..15. After the last value it returns to 0. The clear input is active low. In one build it acts asynchronously. In the other it acts only at a rising clock edge. Every count and every parallel load takes effect on the rising edge of the clock.

Two count enables control the stage, and it advances only when both are high. The terminal-count flag marks the last value of the sequence and is qualified only by the trickle enable. To build a wider synchronous counter, feed each stage's flag into the trickle enable of the next stage. A single shared parallel enable then starts or stops the whole chain in one cycle.

Top module: `cascade_counter`

## Requirements
- R1: With ASYNC_CLR=1, count_o is 0 while rst_ni is low, with no clock edge needed, whatever the other inputs are.
- R2: With ASYNC_CLR=0, rst_ni low changes nothing between edges. At the next rising edge count_o becomes 0, even when load_ni is low and both enables are high.
- R3: With the clear inactive and load_ni low, count_o takes data_i at the rising edge, whatever the count enables are.
- R4: With the clear and load inactive and both cen_par_i and cen_trk_i high, count_o advances by one at the rising edge. For modulus 16 the value 15 is followed by 0.
- R5: For modulus 10 the value 9 is followed by 0. A loaded value from 10 to 15 is also followed by 0 on the next count.
- R6: With the clear and load inactive and either enable low, count_o keeps its value.
- R7: tc_o is 1 exactly when cen_trk_i is 1 and count_o equals the last value (9 for modulus 10, 15 for modulus 16). cen_par_i has no effect on tc_o.
- R8: When three stages are chained, with each tc_o driving the next cen_trk_i and cen_par_i shared, they count as one 12-bit counter: modulo 4096 in binary and modulo 1000 in decimal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Active-low clear, asynchronous or synchronous according to ASYNC_CLR |
| load_ni | input | 1 | Active-low parallel load |
| data_i | input | WIDTH | Parallel load value |
| cen_par_i | input | 1 | Parallel count enable |
| cen_trk_i | input | 1 | Trickle count enable, also qualifies tc_o |
| count_o | output | WIDTH | Current count |
| tc_o | output | 1 | Terminal-count flag |

## Verification
Two kinds of coincidence matter here: a clear arriving together with a load and an active count, and a load arriving while both enables are high. The bench builds both clear styles side by side as 12-bit chains and drives them from the same inputs. It drops rst_ni partway through a clock phase while a load and a count are also requested. The asynchronous chain must read zero before the next edge. The synchronous chain must keep its value until that edge and then read zero. Separately, every 12-bit value is loaded with both enables high and then counted once. The result is compared with an arithmetic digit-by-digit model, which also covers the out-of-range decimal digits.

// File: rtl/cascade_cnt_pkg.sv
package cascade_cnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/cnt_op_decode.sv
module cnt_op_decode
  import cascade_cnt_pkg::*;
#(
  parameter bit SYNC_CLR = 1'b0
) (
  input  logic    clr_ni,
  input  logic    load_ni,
  input  logic    cen_par_i,
  input  logic    cen_trk_i,
  output cnt_op_e op_o
);
  logic clr_req;

  generate
    if (SYNC_CLR) begin : g_sync_clr
      assign clr_req = ~clr_ni;
    end else begin : g_async_clr
      // clear handled by the register's asynchronous path
      assign clr_req = 1'b0;
    end
  endgenerate

  always_comb begin
    if (clr_req)                       op_o = OP_CLEAR;
    else if (!load_ni)                 op_o = OP_LOAD;
    else if (cen_par_i && cen_trk_i)   op_o = OP_COUNT;
    else                               op_o = OP_HOLD;
  end
endmodule

// File: rtl/cnt_next_state.sv
module cnt_next_state
  import cascade_cnt_pkg::*;
#(
  parameter int WIDTH   = 4,
  parameter int MODULUS = 16
) (
  input  logic [WIDTH-1:0] cur_i,
  input  logic [WIDTH-1:0] data_i,
  input  cnt_op_e          op_i,
  output logic [WIDTH-1:0] nxt_o
);
  localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);

  logic [WIDTH-1:0] inc;

  // values at or above the last code (only reachable by load) wrap to zero
  assign inc = (cur_i >= LAST) ? '0 : cur_i + 1'b1;

  always_comb begin
    unique case (op_i)
      OP_CLEAR: nxt_o = '0;
      OP_LOAD:  nxt_o = data_i;
      OP_COUNT: nxt_o = inc;
      default:  nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/cnt_state_reg.sv
module cnt_state_reg #(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic             clk_i,
  input  logic             clr_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  generate
    if (ASYNC_CLR) begin : g_async
      always_ff @(posedge clk_i or negedge clr_ni) begin
        if (!clr_ni) q_o <= '0;
        else         q_o <= d_i;
      end
    end else begin : g_sync
      always_ff @(posedge clk_i) begin
        q_o <= d_i;
      end
    end
  endgenerate
endmodule

// File: rtl/cnt_tc_decode.sv
module cnt_tc_decode #(
  parameter int WIDTH   = 4,
  parameter int MODULUS = 16
) (
  input  logic [WIDTH-1:0] cnt_i,
  input  logic             cen_trk_i,
  output logic             tc_o
);
  localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);

  assign tc_o = cen_trk_i && (cnt_i == LAST);
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
  import cascade_cnt_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter int MODULUS   = 16,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             cen_par_i,
  input  logic             cen_trk_i,
  output logic [WIDTH-1:0] count_o,
  output logic             tc_o
);
  localparam bit SYNC_CLR = !ASYNC_CLR;

  cnt_op_e          op;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;

  cnt_op_decode #(
    .SYNC_CLR (SYNC_CLR)
  ) u_decode (
    .clr_ni    (rst_ni),
    .load_ni   (load_ni),
    .cen_par_i (cen_par_i),
    .cen_trk_i (cen_trk_i),
    .op_o      (op)
  );

  cnt_next_state #(
    .WIDTH   (WIDTH),
    .MODULUS (MODULUS)
  ) u_next (
    .cur_i  (cnt_q),
    .data_i (data_i),
    .op_i   (op),
    .nxt_o  (cnt_d)
  );

  cnt_state_reg #(
    .WIDTH     (WIDTH),
    .ASYNC_CLR (ASYNC_CLR)
  ) u_reg (
    .clk_i  (clk_i),
    .clr_ni (rst_ni),
    .d_i    (cnt_d),
    .q_o    (cnt_q)
  );

  cnt_tc_decode #(
    .WIDTH   (WIDTH),
    .MODULUS (MODULUS)
  ) u_tc (
    .cnt_i     (cnt_q),
    .cen_trk_i (cen_trk_i),
    .tc_o      (tc_o)
  );

  assign count_o = cnt_q;
endmodule

// File: rtl/cascade_counter_chk.sv
module cascade_counter_chk #(
  parameter int WIDTH     = 4,
  parameter int MODULUS   = 16,
  parameter bit ASYNC_CLR = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_ni,
  input logic [WIDTH-1:0] data_i,
  input logic             cen_par_i,
  input logic             cen_trk_i,
  input logic [WIDTH-1:0] count_o,
  input logic             tc_o
);
  localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);

  generate
    if (ASYNC_CLR) begin : g_a_async
      a_r1_async_clear: assert property (@(posedge clk_i)
        !rst_ni |-> count_o == '0);
    end else begin : g_a_sync
      a_r2_sync_clear: assert property (@(posedge clk_i)
        !rst_ni |=> count_o == '0);
    end
  endgenerate

  a_r3_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> count_o == $past(data_i));

  a_r4_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && cen_par_i && cen_trk_i && $past(rst_ni) && count_o < LAST)
      |=> count_o == $past(count_o) + 1'b1);

  a_r5_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && cen_par_i && cen_trk_i && count_o >= LAST) |=> count_o == '0);

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !(cen_par_i && cen_trk_i)) |=> $stable(count_o));

  a_r7_tc_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> count_o == LAST);

  a_r7_tc_trickle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cen_trk_i && count_o == LAST) |-> tc_o);
endmodule

bind cascade_counter cascade_counter_chk #(
  .WIDTH     (WIDTH),
  .MODULUS   (MODULUS),
  .ASYNC_CLR (ASYNC_CLR)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .load_ni   (load_ni),
  .data_i    (data_i),
  .cen_par_i (cen_par_i),
  .cen_trk_i (cen_trk_i),
  .count_o   (count_o),
  .tc_o      (tc_o)
);

// File: tb/cascade_counter_tb.sv
`timescale 1ns/1ps
module cascade_counter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_n = 1'b1;
  logic        par = 1'b0;
  logic        trk = 1'b0;
  logic [11:0] data = '0;

  int checks = 0;
  int errors = 0;

  logic [11:0] ma, mb;   // expected chain values: A binary async, B decimal sync

  always #4 clk = ~clk;

  logic [3:0] qa0, qa1, qa2, qb0, qb1, qb2;
  logic       ta0, ta1, ta2, tb0, tb1, tb2;

  // chain A: binary, asynchronous clear
  cascade_counter #(.WIDTH(4), .MODULUS(16), .ASYNC_CLR(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(load_n), .data_i(data[3:0]),
    .cen_par_i(par), .cen_trk_i(trk), .count_o(qa0), .tc_o(ta0));
  cascade_counter #(.WIDTH(4), .MODULUS(16), .ASYNC_CLR(1'b1)) u_a1 (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(load_n), .data_i(data[7:4]),
    .cen_par_i(par), .cen_trk_i(ta0), .count_o(qa1), .tc_o(ta1));
  cascade_counter #(.WIDTH(4), .MODULUS(16), .ASYNC_CLR(1'b1)) u_a2 (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(load_n), .data_i(data[11:8]),
    .cen_par_i(par), .cen_trk_i(ta1), .count_o(qa2), .tc_o(ta2));

  // chain B: decimal, synchronous clear
  cascade_counter #(.WIDTH(4), .MODULUS(10), .ASYNC_CLR(1'b0)) u_b0 (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(load_n), .data_i(data[3:0]),
    .cen_par_i(par), .cen_trk_i(trk), .count_o(qb0), .tc_o(tb0));
  cascade_counter #(.WIDTH(4), .MODULUS(10), .ASYNC_CLR(1'b0)) u_b1 (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(load_n), .data_i(data[7:4]),
    .cen_par_i(par), .cen_trk_i(tb0), .count_o(qb1), .tc_o(tb1));
  cascade_counter #(.WIDTH(4), .MODULUS(10), .ASYNC_CLR(1'b0)) u_b2 (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(load_n), .data_i(data[11:8]),
    .cen_par_i(par), .cen_trk_i(tb1), .count_o(qb2), .tc_o(tb2));

  // one rising edge of a 3-digit chain, clear excluded
  function automatic logic [11:0] adv(logic [11:0] v, int last, logic t,
                                      logic p, logic ld_n, logic [11:0] d);
    logic [11:0] r;
    logic        carry;
    if (!ld_n) return d;
    carry = t;
    r = v;
    for (int k = 0; k < 3; k++) begin
      int  dig;
      logic tck;
      dig = int'(v[4*k +: 4]);
      tck = carry && (dig == last);
      if (carry && p) dig = (dig >= last) ? 0 : dig + 1;
      r[4*k +: 4] = 4'(dig);
      carry = tck;
    end
    return r;
  endfunction

  function automatic logic [2:0] tcs(logic [11:0] v, int last, logic t);
    logic [2:0] r;
    logic       carry;
    carry = t;
    for (int k = 0; k < 3; k++) begin
      r[k]  = carry && (int'(v[4*k +: 4]) == last);
      carry = r[k];
    end
    return r;
  endfunction

  task automatic cmp(string req, string what, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%03h expected=%03h", req, what, act, exp);
    end
  endtask

  task automatic chk(string req);
    cmp(req, "chainA count", {qa2, qa1, qa0}, ma);
    cmp(req, "chainA tc", {9'd0, ta2, ta1, ta0}, {9'd0, tcs(ma, 15, trk)});
    cmp(req, "chainB count", {qb2, qb1, qb0}, mb);
    cmp(req, "chainB tc", {9'd0, tb2, tb1, tb0}, {9'd0, tcs(mb, 9, trk)});
  endtask

  // inputs already driven after a falling edge; take one rising edge
  task automatic step(string req);
    @(posedge clk);
    if (!rst_n) begin
      ma = '0;
      mb = '0;
    end else begin
      ma = adv(ma, 15, trk, par, load_n, data);
      mb = adv(mb, 9, trk, par, load_n, data);
    end
    @(negedge clk);
    chk(req);
  endtask

  task automatic drive(logic r, logic ld, logic p, logic t, logic [11:0] d);
    rst_n = r; load_n = ld; par = p; trk = t; data = d;
  endtask

  // clear dropped mid-phase together with a load and an active count
  task automatic clear_mid();
    #2;
    drive(1'b0, 1'b0, 1'b1, 1'b1, 12'(($urandom)));
    #1;
    cmp("R1", "async clear before edge", {qa2, qa1, qa0}, 12'h000);
    cmp("R2", "sync clear waits for edge", {qb2, qb1, qb0}, mb);
    ma = '0;
    step("R2");
    drive(1'b1, 1'b1, 1'b0, 1'b0, '0);
  endtask

  initial begin
    ma = '0;
    mb = '0;
    drive(1'b0, 1'b1, 1'b1, 1'b1, 12'h5a5);
    repeat (3) step("R1");
    drive(1'b1, 1'b1, 1'b1, 1'b1, '0);

    // free run across the full range of both chains
    for (int i = 0; i < 5000; i++) step("R8");

    // hold with either enable low
    drive(1'b1, 1'b1, 1'b0, 1'b1, '0);
    for (int i = 0; i < 40; i++) step("R6");
    drive(1'b1, 1'b1, 1'b1, 1'b0, '0);
    for (int i = 0; i < 40; i++) step("R6");

    // every load value, loaded with both enables high, then counted once
    for (int v = 0; v < 4096; v++) begin
      drive(1'b1, 1'b0, 1'b1, 1'b1, 12'(v));
      step("R3");
      drive(1'b1, 1'b1, 1'b1, 1'b1, 12'(v));
      step("R5");
    end

    // terminal count gated by trickle enable, not by parallel enable
    drive(1'b1, 1'b0, 1'b0, 1'b1, 12'h999);
    step("R7");
    drive(1'b1, 1'b1, 1'b0, 1'b1, '0);
    step("R7");
    trk = 1'b0;
    #1 chk("R7");
    drive(1'b1, 1'b0, 1'b0, 1'b1, 12'hfff);
    step("R7");
    drive(1'b1, 1'b1, 1'b1, 1'b1, '0);
    step("R4");

    for (int i = 0; i < 16; i++) begin
      clear_mid();
      drive(1'b1, 1'b1, 1'b1, 1'b1, '0);
      for (int j = 0; j < 30; j++) step("R4");
    end

    // random mix
    for (int i = 0; i < 20000; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      drive(r[7:1] != 7'd0, r[2:0] != 3'd0, r[3] | r[5], r[4] | r[6],
            12'($urandom));
      step(!rst_n ? "R2" : (!load_n ? "R3" : ((par && trk) ? "R4" : "R6")));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule